// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The host issues one read or one write at a time. The controller registers the address and the write data, then drives the active-low chip-enable, write-enable and output-enable strobes. It holds each phase for a whole number of clock cycles, so the memory's nanosecond minimums are met at any clock period the parameters describe.

Every phase length is worked out at elaboration time as `ceil(t_ns / CLK_PERIOD_NS)`, with a floor of one cycle.

The bidirectional data bus is split into an outgoing value, an incoming value and a drive enable. Output-enable stays high for the whole write. After every read there is an idle gap that covers the memory's bus-release time. As a result, the controller and the memory never drive the data bus at the same time. Read data comes back with a one-cycle valid strobe, and a write ends with a one-cycle done pulse.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `ready_o` is 1, all three strobes (`sram_ce_n_o`, `sram_we_n_o`, `sram_oe_n_o`) are 1, and `sram_dq_oe_o`, `rdata_valid_o` and `wr_done_o` are 0.
- R2: A request is taken only on a clock edge where `req_i` and `ready_o` are both 1, and `ready_o` drops in the next cycle. A request raised while `ready_o` is 0 leaves the memory unchanged.
- R3: A write (`we_i`=1) holds chip-enable and write-enable low together for WR = max(ceil(40/T), ceil(45/T), ceil(25/T)) cycles, with T the clock period in ns; this is 9 at T=5. Output-enable stays high and the data drivers are on only while write-enable is low.
- R4: `wr_done_o` pulses for exactly one cycle, in the first cycle after write-enable rises. `ready_o` returns max(ceil(55/T), WR+1) cycles after acceptance; this is 11 at T=5.
- R5: A read (`we_i`=0) holds chip-enable and output-enable low with write-enable high for RD = max(ceil(55/T), ceil(25/T)) cycles; this is 11 at T=5. The data bus is sampled at the edge that ends that phase, and `rdata_valid_o` pulses for one cycle right after.
- R6: After a read, the strobes stay high and the drivers stay off for ceil(20/T) cycles (4 at T=5) before `ready_o` returns. The controller never enables its drivers while the memory may still drive the bus, including a write issued straight after a read.
- R7: `sram_addr_o` stays stable for every cycle that chip-enable is low.
- R8: Address and write data are captured at acceptance. Changes on `addr_i` or `wdata_i` during an access have no effect on what is written.
- R9: `rdata_o` keeps the last read value until the next read completes, including across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Host address |
| wdata_i | input | 8 | Host write data |
| ready_o | output | 1 | Controller idle, request accepted on this edge |
| rdata_o | output | 8 | Captured read data |
| rdata_valid_o | output | 1 | One-cycle read completion strobe |
| wr_done_o | output | 1 | One-cycle write completion strobe |
| sram_addr_o | output | 15 | Memory address |
| sram_ce_n_o | output | 1 | Chip enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_dq_o | output | 8 | Data to drive onto the bus |
| sram_dq_i | input | 8 | Data sampled from the bus |
| sram_dq_oe_o | output | 1 | Drive enable for `sram_dq_o` |

## Verification
The assertions assume that the host keeps `req_i`, `we_i`, `addr_i` and `wdata_i` steady around each rising edge, and that `sram_dq_i` is settled at the edge that ends a read.

The bench drives all host inputs and the memory model's bus value on the falling edge. The model holds back valid read data until one ns before the access time has passed. It also records how long each write overlap lasts and how long the bus stays driven after each read, and flags any drive overlap or short write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR   = 3'd1,
    ST_REC  = 3'd2,
    ST_RD   = 3'd3,
    ST_TURN = 3'd4
  } ctrl_state_e;

  // cycles covering a nanosecond minimum, never fewer than one
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

  p_timer_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (load_val_i != '0) |=> !last_o);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              valid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(rdata_o));

  p_valid_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned T_WP_NS       = 40,
  parameter int unsigned T_AW_NS       = 45,
  parameter int unsigned T_DS_NS       = 25,
  parameter int unsigned T_WC_NS       = 55,
  parameter int unsigned T_AA_NS       = 55,
  parameter int unsigned T_RC_NS       = 55,
  parameter int unsigned T_DOE_NS      = 25,
  parameter int unsigned T_HZOE_NS     = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic              wr_done_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_n_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o
);

  localparam int unsigned WR_CYC   = max2(max2(ns2cyc(T_WP_NS, CLK_PERIOD_NS),
                                               ns2cyc(T_AW_NS, CLK_PERIOD_NS)),
                                          ns2cyc(T_DS_NS, CLK_PERIOD_NS));
  localparam int unsigned WC_CYC   = ns2cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC  = (WC_CYC > WR_CYC) ? WC_CYC - WR_CYC : 1;
  localparam int unsigned RD_CYC   = max2(max2(ns2cyc(T_AA_NS, CLK_PERIOD_NS),
                                               ns2cyc(T_RC_NS, CLK_PERIOD_NS)),
                                          ns2cyc(T_DOE_NS, CLK_PERIOD_NS));
  localparam int unsigned TURN_CYC = ns2cyc(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC  = max2(max2(WR_CYC, REC_CYC), max2(RD_CYC, TURN_CYC));
  localparam int unsigned CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  ctrl_state_e       state_q, state_d;
  logic              tmr_load, tmr_last, cap, done_d;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap      = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        tmr_load = 1'b1;
        if (we_i) begin
          state_d = ST_WR;
          tmr_val = CNT_W'(WR_CYC - 1);
        end else begin
          state_d = ST_RD;
          tmr_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_WR: if (tmr_last) begin
        state_d  = ST_REC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(REC_CYC - 1);
        done_d   = 1'b1;
      end
      ST_REC:  if (tmr_last) state_d = ST_IDLE;
      ST_RD: if (tmr_last) begin
        state_d  = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TURN_CYC - 1);
        cap      = 1'b1;
      end
      ST_TURN: if (tmr_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      wr_done_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      wr_done_o <= done_d;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .last_o     (tmr_last)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .dq_i    (sram_dq_i),
    .rdata_o (rdata_o),
    .valid_o (rdata_valid_o)
  );

  assign ready_o      = (state_q == ST_IDLE);
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = wdata_q;
  assign sram_ce_n_o  = !((state_q == ST_WR) || (state_q == ST_RD));
  assign sram_we_n_o  = (state_q != ST_WR);
  assign sram_oe_n_o  = (state_q != ST_RD);
  assign sram_dq_oe_o = (state_q == ST_WR);

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o |=> !ready_o);

  p_we_within_ce_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> !sram_ce_n_o && sram_oe_n_o);

  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |=> !wr_done_o);

  p_done_after_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> sram_we_n_o && $past(!sram_we_n_o));

  p_no_drive_on_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_n_o && !sram_we_n_o);

  p_read_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_n_o) |-> !ready_o);

  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_ce_n_o && $past(!sram_ce_n_o) |-> $stable(sram_addr_o));

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PER     = 5;
  localparam int WR_EXP  = 9;   // max(ceil(40/5), ceil(45/5), ceil(25/5))
  localparam int BUSY_WR = 11;  // max(ceil(55/5), WR+1)
  localparam int RD_EXP  = 11;  // max(ceil(55/5), ceil(25/5))
  localparam int BUSY_RD = 15;  // RD + ceil(20/5)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid, wdone, ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [14:0] saddr;

  int n_cmp = 0, n_bad = 0;
  int contention = 0, short_wr = 0;

  always #(PER/2.0) clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .rdata_valid_o(rvalid),
    .wr_done_o(wdone), .sram_addr_o(saddr), .sram_ce_n_o(ce_n),
    .sram_we_n_o(we_n), .sram_oe_n_o(oe_n), .sram_dq_o(dq_o),
    .sram_dq_i(dq_i), .sram_dq_oe_o(dq_oe)
  );

  // memory model
  logic [7:0] mem [int];
  wire wr_on = !ce_n && !we_n;
  wire rd_on = !ce_n && !oe_n && we_n;
  realtime wr_start = 0, rel_until = 0;
  logic rd_ok = 1'b0;

  function automatic logic [7:0] mem_get(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge wr_on) wr_start = $realtime;
  always @(negedge wr_on) begin
    if ($realtime - wr_start < 45.0) short_wr++;
    mem[int'(saddr)] = dq_o;
  end
  always @(posedge rd_on) begin
    rd_ok = 1'b0;
    #54;
    rd_ok = rd_on;
  end
  always @(negedge rd_on) begin
    rd_ok = 1'b0;
    rel_until = $realtime + 20.0;
  end
  assign dq_i = !rd_on ? 8'h00 : (rd_ok ? mem_get(int'(saddr)) : ~mem_get(int'(saddr)));

  always @(negedge clk)
    if (rst_n && dq_oe && (rd_on || $realtime < rel_until)) contention++;

  task automatic check(input string req_tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
    end
  endtask

  // issue one request; host inputs are scrambled after acceptance (R8)
  task automatic issue(input logic w, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; addr = ~a; wdata = ~d;
  endtask

  task automatic t_reset();
    check("R1", "ready", ready, 1);
    check("R1", "ce_n", ce_n, 1);
    check("R1", "we_n", we_n, 1);
    check("R1", "oe_n", oe_n, 1);
    check("R1", "dq_oe", dq_oe, 0);
    check("R1", "pulses", {rvalid, wdone}, 0);
  endtask

  task automatic t_write(input logic [14:0] a, input logic [7:0] d, input bit poke);
    int k = 0, we_low = 0, done_at = -1, done_cnt = 0, bad_oe = 0, rdy_at = -1;
    issue(1'b1, a, d);
    while (k < 40) begin
      if (!we_n) begin
        we_low++;
        if (!oe_n || !dq_oe) bad_oe++;
      end else if (dq_oe) bad_oe++;
      if (wdone) begin done_cnt++; if (done_at < 0) done_at = k; end
      if (ready) begin rdy_at = k; break; end
      if (poke && k == 2) begin req = 1'b1; we = 1'b1; addr = a ^ 15'h0400; wdata = 8'h5A; end
      if (poke && k == 3) req = 1'b0;
      @(posedge clk); @(negedge clk);
      k++;
    end
    check("R3", "we low cycles", we_low, WR_EXP);
    check("R3", "oe/driver misuse", bad_oe, 0);
    check("R4", "done cycle", done_at, WR_EXP);
    check("R4", "done count", done_cnt, 1);
    check("R4", "ready cycle", rdy_at, BUSY_WR);
  endtask

  task automatic t_read(input logic [14:0] a, input logic [7:0] exp);
    int k = 0, oe_low = 0, v_at = -1, rdy_at = -1, addr_moves = 0;
    logic [14:0] a0;
    issue(1'b0, a, 8'h00);
    a0 = saddr;
    while (k < 40) begin
      if (!oe_n) begin
        oe_low++;
        if (we_n !== 1'b1 || ce_n !== 1'b0) oe_low += 100;
      end
      if (!ce_n && saddr !== a0) addr_moves++;
      if (rvalid && v_at < 0) begin
        v_at = k;
        check("R5", "read data", rdata, exp);
      end
      if (ready) begin rdy_at = k; break; end
      @(posedge clk); @(negedge clk);
      k++;
    end
    check("R5", "oe low cycles", oe_low, RD_EXP);
    check("R5", "valid cycle", v_at, RD_EXP);
    check("R6", "ready after gap", rdy_at, BUSY_RD);
    check("R7", "address moved", addr_moves, 0);
    check("R7", "address value", a0, a);
  endtask

  task automatic t_basic();
    t_write(15'h0000, 8'h3C, 1'b0);
    t_write(15'h7FFF, 8'hC3, 1'b0);
    t_write(15'h1234, 8'hA5, 1'b0);
    t_read(15'h0000, 8'h3C);
    t_read(15'h7FFF, 8'hC3);
    t_read(15'h1234, 8'hA5);
  endtask

  task automatic t_busy_ignore();
    t_write(15'h0100, 8'h11, 1'b1);
    t_read(15'h0500, 8'h00);  // R2: poked address never written
    t_read(15'h0100, 8'h11);
  endtask

  task automatic t_host_change();
    // R8: issue scrambles addr_i/wdata_i right after acceptance
    t_write(15'h2222, 8'h77, 1'b0);
    t_read(15'h2222, 8'h77);
    t_read(~15'h2222, 8'h00);
  endtask

  task automatic t_rdata_hold();
    t_read(15'h1234, 8'hA5);
    t_write(15'h3333, 8'h99, 1'b0);
    check("R9", "rdata held across write", rdata, 8'hA5);
    check("R9", "valid quiet", rvalid, 0);
  endtask

  task automatic t_turnaround();
    t_read(15'h7FFF, 8'hC3);
    t_write(15'h7FFF, 8'h0F, 1'b0);  // write straight after read
    t_read(15'h7FFF, 8'h0F);
    check("R6", "bus contention events", contention, 0);
    check("R3", "short write overlaps", short_wr, 0);
  endtask

  initial begin : watchdog
    #(PER * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy_ignore();
    t_host_change();
    t_rdata_hold();
    t_turnaround();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule